// File: doc/BRIEF.md
# Exception Entry Controller

This block carries out the architectural side of taking a processor exception. When the pipeline raises a one-cycle request, the request carries a fault kind, the faulting PC and the next PC, the faulting virtual address, an address-space identifier and a coprocessor number. In the same clock edge the block commits every control-register change that the entry implies. One cycle later it presents the handler address on a registered redirect output with a one-cycle strobe.

The block holds eight 32-bit control registers: status, cause, exception PC, bad address, shadow-set control, translation entry-high, translation context and exception base. Software reaches them through a small port with a combinational read path and a write that takes effect at the next edge.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, status reads 0x2000_0000 (only the coprocessor-1 usable bit, bit 29, is set), exception base reads 0x8000_0000, every other register reads 0, and `redirect` is low.
- R2: `redirect` is high for exactly the one cycle after each cycle in which `exc_valid` is high, and low otherwise. `redirect_pc` carries the handler address in that cycle.
- R3: Every exception entry sets status bit 1 (exception level), whether or not it was already set.
- R4: The shadow-set control changes only when status bits 1 and 22 (boot vectors) were both 0 before entry. When it changes, bits 9:6 (previous set) take bits 3:0 (current set), and bits 3:0 take bits 15:12 (exception set). Otherwise it is left unchanged.
- R5: If `exc_npc` differs from `exc_pc`+4, the exception PC becomes `exc_pc`-4 and cause bit 31 is set. Otherwise the exception PC becomes `exc_pc` and cause bit 31 is cleared.
- R6: Cause bits 6:2 receive the code of the fault kind and cause bits 29:28 are cleared. For the coprocessor-unusable kind, bits 29:28 receive `exc_cop` instead. The kind encoding is `exc_kind` → code: 0 interrupt→0, 1 TLB modified→1, 2 instruction refill→2, 3 instruction TLB invalid→2, 4 data refill→3, 5 data TLB invalid→3, 6 load address error→4, 7 store address error→5, 8 system call→8, 9 breakpoint→9, 10 reserved instruction→10, 11 coprocessor unusable→11, 12 overflow→12, 13 trap→13. Values 14 and 15 behave as trap.
- R7: Kinds without a special rule vector to exception base + 0x180.
- R8: The refill kinds (2 and 4) vector to exception base + 0x000 when status bit 1 was 0 before entry, and to base + 0x180 when it was 1.
- R9: An interrupt vectors to base + 0x200 when cause bit 23 is 1, and to base + 0x180 when it is 0.
- R10: An overflow (kind 12) taken while status bit 22 is 1 vectors to the fixed address 0xBFC0_0200.
- R11: The TLB kinds (1 to 5) load the bad-address register with `exc_vaddr`. They write entry-high bits 31:13 with address bits 31:13 and entry-high bits 7:0 with `exc_asid`, and they write context bits 22:4 with address bits 31:13. All other bits of entry-high and context keep their values.
- R12: The address-error kinds (6, 7) load only the bad-address register. All remaining kinds leave bad-address, entry-high and context unchanged.
- R13: Register port select: 0 status, 1 cause, 2 exception PC, 3 bad address, 4 shadow-set control, 5 entry-high, 6 context, 7 exception base. Reads are combinational. A write lands at the next edge, with exception-base bits 11:0 forced to 0. A write presented in the same cycle as `exc_valid` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | One-cycle exception request |
| exc_kind | input | 4 | Fault kind (R6 encoding) |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_npc | input | 32 | Next PC at the time of the fault |
| exc_vaddr | input | 32 | Faulting virtual address |
| exc_asid | input | 8 | Address-space identifier for entry-high |
| exc_cop | input | 2 | Coprocessor number for unusable faults |
| reg_we | input | 1 | Register port write enable |
| reg_sel | input | 3 | Register port select |
| reg_wdata | input | 32 | Register port write data |
| reg_rdata | output | 32 | Register port read data |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | Handler address |

## Verification
A software write and an exception entry can fall in the same cycle. The bench provokes this by raising `reg_we` on the exception-PC and status selects in the very cycle that `exc_valid` is high. It then reads those registers back and expects the values the exception produced, with no trace of the written data. A second overlap is the vector choice against the status change: the refill and overflow cases are set up so that the handler address must come from status as it stood before the entry sets bit 1.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XW     = 32;
    localparam int ASID_W = 8;
    localparam int CE_W   = 2;
    localparam int CODE_W = 5;
    localparam int SRS_W  = 4;

    // status fields
    localparam int ST_EXL = 1;
    localparam int ST_BEV = 22;
    localparam int ST_CU1 = 29;
    // cause fields
    localparam int CA_CODE_LO = 2;
    localparam int CA_IV      = 23;
    localparam int CA_CE_LO   = 28;
    localparam int CA_BD      = 31;
    // shadow-set control fields
    localparam int SRS_CUR_LO  = 0;
    localparam int SRS_PREV_LO = 6;
    localparam int SRS_EXC_LO  = 12;
    // translation fields
    localparam int VPN_LO = 13;
    localparam int VPN_W  = XW - VPN_LO;
    localparam int CTX_LO = 4;
    localparam int BASE_ALIGN = 12;

    localparam logic [XW-1:0] OFF_GENERAL = 32'h0000_0180;
    localparam logic [XW-1:0] OFF_IVEC    = 32'h0000_0200;
    localparam logic [XW-1:0] BOOT_VECTOR = 32'hBFC0_0200;

    typedef enum logic [3:0] {
        EK_INT       = 4'd0,
        EK_TLB_MOD   = 4'd1,
        EK_IREFILL   = 4'd2,
        EK_IINVALID  = 4'd3,
        EK_DREFILL   = 4'd4,
        EK_DINVALID  = 4'd5,
        EK_ADDR_LD   = 4'd6,
        EK_ADDR_ST   = 4'd7,
        EK_SYSCALL   = 4'd8,
        EK_BREAK     = 4'd9,
        EK_RESVD     = 4'd10,
        EK_COP_UNUSE = 4'd11,
        EK_OVERFLOW  = 4'd12,
        EK_TRAP      = 4'd13,
        EK_SPARE0    = 4'd14,
        EK_SPARE1    = 4'd15
    } exc_kind_e;

    typedef enum logic [2:0] {
        RS_STATUS = 3'd0,
        RS_CAUSE  = 3'd1,
        RS_EPC    = 3'd2,
        RS_BADVA  = 3'd3,
        RS_SHADOW = 3'd4,
        RS_ENTHI  = 3'd5,
        RS_CTX    = 3'd6,
        RS_EBASE  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [XW-1:0] status;
        logic [XW-1:0] cause;
        logic [XW-1:0] epc;
        logic [XW-1:0] badva;
        logic [XW-1:0] shadow;
        logic [XW-1:0] enthi;
        logic [XW-1:0] ctx;
        logic [XW-1:0] ebase;
    } ctrl_regs_t;

    function automatic logic [CODE_W-1:0] code_of(exc_kind_e k);
        case (k)
            EK_INT:                   return 5'd0;
            EK_TLB_MOD:               return 5'd1;
            EK_IREFILL, EK_IINVALID:  return 5'd2;
            EK_DREFILL, EK_DINVALID:  return 5'd3;
            EK_ADDR_LD:               return 5'd4;
            EK_ADDR_ST:               return 5'd5;
            EK_SYSCALL:               return 5'd8;
            EK_BREAK:                 return 5'd9;
            EK_RESVD:                 return 5'd10;
            EK_COP_UNUSE:             return 5'd11;
            EK_OVERFLOW:              return 5'd12;
            default:                  return 5'd13;
        endcase
    endfunction

    function automatic logic is_tlb(exc_kind_e k);
        return (k >= EK_TLB_MOD) && (k <= EK_DINVALID);
    endfunction

    function automatic logic is_addr_err(exc_kind_e k);
        return (k == EK_ADDR_LD) || (k == EK_ADDR_ST);
    endfunction

    function automatic logic is_refill(exc_kind_e k);
        return (k == EK_IREFILL) || (k == EK_DREFILL);
    endfunction

endpackage

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_entry_pkg::*;
(
    input  exc_kind_e     kind,
    input  logic [XW-1:0] status,
    input  logic [XW-1:0] cause,
    input  logic [XW-1:0] ebase,
    output logic [XW-1:0] vector
);
    logic [XW-1:0] offset;
    logic          use_boot;

    always_comb begin
        use_boot = 1'b0;
        offset   = OFF_GENERAL;
        if (is_refill(kind)) begin
            offset = status[ST_EXL] ? OFF_GENERAL : '0;
        end else if (kind == EK_INT) begin
            offset = cause[CA_IV] ? OFF_IVEC : OFF_GENERAL;
        end else if (kind == EK_OVERFLOW) begin
            use_boot = status[ST_BEV];
        end
        vector = use_boot ? BOOT_VECTOR : (ebase + offset);
    end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
    import exc_entry_pkg::*;
#(
    parameter logic [XW-1:0] EBASE_RST  = 32'h8000_0000,
    parameter logic [XW-1:0] STATUS_RST = 32'h2000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_valid,
    input  exc_kind_e         kind,
    input  logic [XW-1:0]     exc_pc,
    input  logic [XW-1:0]     exc_npc,
    input  logic [XW-1:0]     exc_vaddr,
    input  logic [ASID_W-1:0] exc_asid,
    input  logic [CE_W-1:0]   exc_cop,
    input  logic              reg_we,
    input  reg_sel_e          reg_sel,
    input  logic [XW-1:0]     reg_wdata,
    output ctrl_regs_t        regs_q
);
    ctrl_regs_t regs_d;
    logic       in_slot;

    assign in_slot = (exc_npc != exc_pc + XW'(4));

    always_comb begin
        regs_d = regs_q;
        if (exc_valid) begin
            if (!regs_q.status[ST_EXL] && !regs_q.status[ST_BEV]) begin
                regs_d.shadow[SRS_PREV_LO +: SRS_W] = regs_q.shadow[SRS_CUR_LO +: SRS_W];
                regs_d.shadow[SRS_CUR_LO +: SRS_W]  = regs_q.shadow[SRS_EXC_LO +: SRS_W];
            end
            regs_d.status[ST_EXL]               = 1'b1;
            regs_d.epc                          = in_slot ? (exc_pc - XW'(4)) : exc_pc;
            regs_d.cause[CA_BD]                 = in_slot;
            regs_d.cause[CA_CODE_LO +: CODE_W]  = code_of(kind);
            regs_d.cause[CA_CE_LO +: CE_W]      = (kind == EK_COP_UNUSE) ? exc_cop : '0;
            if (is_tlb(kind) || is_addr_err(kind)) begin
                regs_d.badva = exc_vaddr;
            end
            if (is_tlb(kind)) begin
                regs_d.enthi[VPN_LO +: VPN_W]   = exc_vaddr[XW-1 -: VPN_W];
                regs_d.enthi[ASID_W-1:0]        = exc_asid;
                regs_d.ctx[CTX_LO +: VPN_W]     = exc_vaddr[XW-1 -: VPN_W];
            end
        end else if (reg_we) begin
            case (reg_sel)
                RS_STATUS: regs_d.status = reg_wdata;
                RS_CAUSE:  regs_d.cause  = reg_wdata;
                RS_EPC:    regs_d.epc    = reg_wdata;
                RS_BADVA:  regs_d.badva  = reg_wdata;
                RS_SHADOW: regs_d.shadow = reg_wdata;
                RS_ENTHI:  regs_d.enthi  = reg_wdata;
                RS_CTX:    regs_d.ctx    = reg_wdata;
                default:   regs_d.ebase  = {reg_wdata[XW-1:BASE_ALIGN], {BASE_ALIGN{1'b0}}};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q        <= '0;
            regs_q.status <= STATUS_RST;
            regs_q.ebase  <= EBASE_RST;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter logic [31:0] EBASE_RST = 32'h8000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        exc_valid,
    input  logic [3:0]  exc_kind,
    input  logic [31:0] exc_pc,
    input  logic [31:0] exc_npc,
    input  logic [31:0] exc_vaddr,
    input  logic [7:0]  exc_asid,
    input  logic [1:0]  exc_cop,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        redirect,
    output logic [31:0] redirect_pc
);
    exc_kind_e     kind;
    reg_sel_e      sel;
    ctrl_regs_t    regs_q;
    logic [XW-1:0] vector;
    logic [XW-1:0] status_q, cause_q, epc_q, shadow_q;

    assign kind     = exc_kind_e'(exc_kind);
    assign sel      = reg_sel_e'(reg_sel);
    assign status_q = regs_q.status;
    assign cause_q  = regs_q.cause;
    assign epc_q    = regs_q.epc;
    assign shadow_q = regs_q.shadow;

    exc_state_regs #(.EBASE_RST(EBASE_RST)) u_state (
        .clk       (clk),
        .rst       (rst),
        .exc_valid (exc_valid),
        .kind      (kind),
        .exc_pc    (exc_pc),
        .exc_npc   (exc_npc),
        .exc_vaddr (exc_vaddr),
        .exc_asid  (exc_asid),
        .exc_cop   (exc_cop),
        .reg_we    (reg_we),
        .reg_sel   (sel),
        .reg_wdata (reg_wdata),
        .regs_q    (regs_q)
    );

    exc_vector_calc u_vector (
        .kind   (kind),
        .status (regs_q.status),
        .cause  (regs_q.cause),
        .ebase  (regs_q.ebase),
        .vector (vector)
    );

    always_comb begin
        case (sel)
            RS_STATUS: reg_rdata = regs_q.status;
            RS_CAUSE:  reg_rdata = regs_q.cause;
            RS_EPC:    reg_rdata = regs_q.epc;
            RS_BADVA:  reg_rdata = regs_q.badva;
            RS_SHADOW: reg_rdata = regs_q.shadow;
            RS_ENTHI:  reg_rdata = regs_q.enthi;
            RS_CTX:    reg_rdata = regs_q.ctx;
            default:   reg_rdata = regs_q.ebase;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect    <= 1'b0;
            redirect_pc <= '0;
        end else begin
            redirect <= exc_valid;
            if (exc_valid) begin
                redirect_pc <= vector;
            end
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
    input logic        clk,
    input logic        rst,
    input logic        exc_valid,
    input logic [3:0]  exc_kind,
    input logic [31:0] exc_pc,
    input logic [31:0] exc_npc,
    input logic        redirect,
    input logic [31:0] redirect_pc,
    input logic [31:0] status_q,
    input logic [31:0] cause_q,
    input logic [31:0] epc_q,
    input logic [31:0] shadow_q
);
    AST_REDIRECT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> redirect) else $error("redirect missing"); // R2

    AST_NO_STRAY_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |=> !redirect) else $error("stray redirect"); // R2

    AST_LEVEL_SET: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> status_q[1]) else $error("level bit not set"); // R3

    AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (rst)
        exc_valid && (status_q[1] || status_q[22]) |=> $stable(shadow_q))
        else $error("shadow set moved"); // R4

    AST_EPC_PLAIN: assert property (@(posedge clk) disable iff (rst)
        exc_valid && (exc_npc == exc_pc + 32'd4) |=> (epc_q == $past(exc_pc)) && !cause_q[31])
        else $error("plain epc wrong"); // R5

    AST_CE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        exc_valid && (exc_kind != 4'd11) |=> cause_q[29:28] == 2'd0)
        else $error("coprocessor field not cleared"); // R6

    AST_REFILL_BASE: assert property (@(posedge clk) disable iff (rst)
        exc_valid && (exc_kind == 4'd2 || exc_kind == 4'd4) && !status_q[1]
        |=> redirect_pc[11:0] == 12'h000) else $error("refill offset wrong"); // R8
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .exc_valid   (exc_valid),
    .exc_kind    (exc_kind),
    .exc_pc      (exc_pc),
    .exc_npc     (exc_npc),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .status_q    (status_q),
    .cause_q     (cause_q),
    .epc_q       (epc_q),
    .shadow_q    (shadow_q)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_valid = 1'b0;
    logic [3:0]  exc_kind = '0;
    logic [31:0] exc_pc = '0, exc_npc = '0, exc_vaddr = '0;
    logic [7:0]  exc_asid = '0;
    logic [1:0]  exc_cop = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        redirect;
    logic [31:0] redirect_pc;

    int checks = 0;
    int errors = 0;
    logic [31:0] m [8];
    logic [31:0] exp_q [$];

    always #5 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_kind(exc_kind),
        .exc_pc(exc_pc), .exc_npc(exc_npc), .exc_vaddr(exc_vaddr),
        .exc_asid(exc_asid), .exc_cop(exc_cop), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .redirect(redirect), .redirect_pc(redirect_pc)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: every redirect must match the oldest expected handler address
    always @(negedge clk) begin
        if (!rst && redirect) begin
            if (exp_q.size() == 0) begin
                check("R2 stray redirect", redirect_pc, 32'hxxxx_xxxx);
            end else begin
                check("R2 R7 R8 R9 R10 handler address", redirect_pc, exp_q.pop_front());
            end
        end
    end

    function automatic logic [4:0] code_for(int k);
        case (k)
            0: return 5'd0;   1: return 5'd1;
            2, 3: return 5'd2; 4, 5: return 5'd3;
            6: return 5'd4;   7: return 5'd5;
            8: return 5'd8;   9: return 5'd9;
            10: return 5'd10; 11: return 5'd11;
            12: return 5'd12;
            default: return 5'd13;
        endcase
    endfunction

    // expected model built from the requirements
    task automatic model_exc(int k, logic [31:0] pc, logic [31:0] npc, logic [31:0] va,
                             logic [7:0] asid, logic [1:0] cop);
        logic [31:0] vec;
        logic exl = m[0][1];
        logic bev = m[0][22];
        logic slot = (npc != pc + 32'd4);
        if (k == 2 || k == 4)      vec = exl ? m[7] + 32'h180 : m[7];
        else if (k == 0)           vec = m[1][23] ? m[7] + 32'h200 : m[7] + 32'h180;
        else if (k == 12 && bev)   vec = 32'hBFC0_0200;
        else                       vec = m[7] + 32'h180;
        exp_q.push_back(vec);
        if (!exl && !bev) begin
            m[4][9:6] = m[4][3:0];
            m[4][3:0] = m[4][15:12];
        end
        m[0][1] = 1'b1;
        m[2] = slot ? pc - 32'd4 : pc;
        m[1][31] = slot;
        m[1][6:2] = code_for(k);
        m[1][29:28] = (k == 11) ? cop : 2'd0;
        if (k >= 1 && k <= 7) m[3] = va;
        if (k >= 1 && k <= 5) begin
            m[5][31:13] = va[31:13];
            m[5][7:0]   = asid;
            m[6][22:4]  = va[31:13];
        end
    endtask

    // driver: one exception, optionally with a colliding software write
    task automatic do_exc(int k, logic [31:0] pc, logic [31:0] npc, logic [31:0] va,
                          logic [7:0] asid, logic [1:0] cop, logic wr, logic [2:0] s,
                          logic [31:0] d);
        @(negedge clk);
        exc_valid = 1'b1; exc_kind = 4'(k); exc_pc = pc; exc_npc = npc;
        exc_vaddr = va; exc_asid = asid; exc_cop = cop;
        reg_we = wr; reg_sel = s; reg_wdata = d;
        model_exc(k, pc, npc, va, asid, cop);
        @(negedge clk);
        exc_valid = 1'b0; reg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic sw_write(logic [2:0] s, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        m[s] = (s == 3'd7) ? {d[31:12], 12'h000} : d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic read_chk(logic [2:0] s, string tag);
        reg_sel = s;
        #1;
        check(tag, reg_rdata, m[s]);
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < 8; i++) read_chk(3'(i), tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m[i] = '0;
        m[0] = 32'h2000_0000;
        m[7] = 32'h8000_0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 redirect after reset", {31'd0, redirect}, 32'd0);
        check_all("R1 reset values");

        // load address error, not in a delay slot
        do_exc(6, 32'h0000_1000, 32'h0000_1004, 32'hDEAD_0001, 8'h11, 2'd0, 1'b0, 3'd0, '0);
        check_all("R3 R5 R6 R7 R12 address error");

        // instruction refill with level already set
        do_exc(2, 32'h0000_2000, 32'h0000_2004, 32'h1234_5678, 8'h22, 2'd0, 1'b0, 3'd0, '0);
        check_all("R8 R11 refill at level one");

        // data refill from level zero, in a delay slot; preserve other entry-high bits
        sw_write(3'd0, 32'h0);
        sw_write(3'd5, 32'h0000_1F00);
        do_exc(4, 32'h0000_3000, 32'h0000_3008, 32'hCAFE_E000, 8'h5A, 2'd0, 1'b0, 3'd0, '0);
        check_all("R5 R8 R11 refill at level zero in slot");

        // interrupts with and without the vector bit
        sw_write(3'd0, 32'h0);
        sw_write(3'd1, 32'h0080_0000);
        do_exc(0, 32'h0000_4000, 32'h0000_4004, '0, 8'h0, 2'd0, 1'b0, 3'd0, '0);
        sw_write(3'd0, 32'h0);
        sw_write(3'd1, 32'h0);
        do_exc(0, 32'h0000_4100, 32'h0000_4104, '0, 8'h0, 2'd0, 1'b0, 3'd0, '0);
        check_all("R9 interrupt");

        // overflow under boot vectors; shadow set must stay put
        sw_write(3'd4, 32'h0000_5003);
        sw_write(3'd0, 32'h0040_0000);
        do_exc(12, 32'h0000_5000, 32'h0000_5004, '0, 8'h0, 2'd0, 1'b0, 3'd0, '0);
        check_all("R4 R10 overflow with boot vectors");

        // shadow set rotation from level zero, then frozen at level one
        sw_write(3'd0, 32'h0);
        do_exc(9, 32'h0000_6000, 32'h0000_6004, '0, 8'h0, 2'd0, 1'b0, 3'd0, '0);
        read_chk(3'd4, "R4 rotation");
        do_exc(13, 32'h0000_6100, 32'h0000_6104, '0, 8'h0, 2'd0, 1'b0, 3'd0, '0);
        read_chk(3'd4, "R4 no rotation at level one");

        // coprocessor unusable, then a system call clears the field
        do_exc(11, 32'h0000_7000, 32'h0000_7004, 32'h7777_7777, 8'h0, 2'd2, 1'b0, 3'd0, '0);
        read_chk(3'd1, "R6 coprocessor number");
        do_exc(8, 32'h0000_7100, 32'h0000_7104, 32'h8888_8888, 8'h33, 2'd3, 1'b0, 3'd0, '0);
        check_all("R6 R12 system call");

        // software writes colliding with exceptions are dropped
        do_exc(10, 32'h0000_8000, 32'h0000_8004, '0, 8'h0, 2'd0, 1'b1, 3'd2, 32'hFFFF_FFFF);
        read_chk(3'd2, "R13 colliding write to exception PC");
        do_exc(10, 32'h0000_8100, 32'h0000_8104, '0, 8'h0, 2'd0, 1'b1, 3'd0, 32'h0);
        read_chk(3'd0, "R13 colliding write to status");

        // base write alignment and a general vector from the new base
        sw_write(3'd7, 32'h9000_0ABC);
        read_chk(3'd7, "R13 base alignment");
        check("R13 base literal", reg_rdata, 32'h9000_0000);
        do_exc(1, 32'h0000_9000, 32'h0000_9004, 32'h4000_2000, 8'h7E, 2'd0, 1'b0, 3'd0, '0);
        check_all("R7 R11 TLB modified from new base");

        repeat (3) @(negedge clk);
        check("R2 all redirects seen", exp_q.size(), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule